// File: doc/BRIEF.md
# DMA Operand Packing Address Sequencer

This block plans and issues the bus cycles for one operand move of a single-channel DMA engine. It holds a source pointer and a destination pointer. A start strobe begins an operand. The block then issues one to two read cycles, followed by one to two write cycles. Bytes are collected in a 16-bit holding register, so data can be packed or unpacked between a byte-wide side and a word-wide side. A word access that falls on an odd address is split into two byte cycles.

The operand sizes, the bus width and the pointer low bits are sampled at start. When the final write is acknowledged without error, each enabled pointer advances by 1, 2 or 4, and a done pulse is raised. An error response aborts the operand and leaves both pointers unchanged. Request generation, byte counting, bus arbitration and bus protocol timing are handled outside this block.

Top module: `dma_pack_seq`

## Requirements
- R1: With `busWide`=0, the size inputs are ignored. The operand is one byte read at the source pointer, then one byte write at the destination pointer, and each enabled pointer steps by 1.
- R2: With `busWide`=1, byte source and byte destination, the operand is one byte read and one byte write, and each enabled pointer steps by 1.
- R3: With `busWide`=1, byte source and word destination, there are two byte reads at S and S+2, then one word write at D. The first byte becomes bits 15:8 of the word. The source pointer steps by 4 and the destination pointer by 2.
- R4: With `busWide`=1, word source and byte destination, there is one word read at S, then byte writes of bits 15:8 at D and bits 7:0 at D+2. The source pointer steps by 2 and the destination pointer by 4.
- R5: With `busWide`=1, word source and word destination at even addresses, there is one word read and one word write, and each enabled pointer steps by 2.
- R6: On a 16-bit bus, a word access at an odd address A becomes byte cycles at A (bits 15:8) and A+1 (bits 7:0). When both pointers are odd, the operand takes four cycles. A word cycle never carries an odd address.
- R7: A pointer whose increment enable is low keeps its address after the operand.
- R8: Pointers change only when the final write is accepted without error, or on a load while idle. `opDone` pulses for one cycle in the cycle after that acceptance. An error response (`cycErr` with `cycAck`) ends the operand, pulses `opErr` instead of `opDone`, and leaves both pointers unchanged.
- R9: A request holds its type, size, address and data until `cycAck`. Byte cycles carry their data on bits 7:0, and write data bits 15:8 are zero for a byte write.
- R10: `start` and `ptrLoad` have no effect while `busy` is high.
- R11: Every completed operand uses between two and four bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ptrLoad | input | 1 | Load both pointers (idle only) |
| srcLoad | input | ADDR_W | Source pointer load value |
| dstLoad | input | ADDR_W | Destination pointer load value |
| srcIncEn | input | 1 | Source pointer increment enable |
| dstIncEn | input | 1 | Destination pointer increment enable |
| busWide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| srcWord | input | 1 | Source operand is a word |
| dstWord | input | 1 | Destination operand is a word |
| start | input | 1 | Begin one operand (idle only) |
| cycReq | output | 1 | Bus cycle request |
| cycWrite | output | 1 | 1 = write cycle, 0 = read cycle |
| cycWord | output | 1 | 1 = word cycle, 0 = byte cycle |
| cycAddr | output | ADDR_W | Cycle address |
| cycWdata | output | 16 | Write data |
| cycRdata | input | 16 | Read data |
| cycAck | input | 1 | Cycle accepted |
| cycErr | input | 1 | Error response, qualified by cycAck |
| busy | output | 1 | Operand in progress |
| opDone | output | 1 | Operand completed pulse |
| opErr | output | 1 | Operand aborted pulse |
| srcPtr | output | ADDR_W | Source pointer |
| dstPtr | output | ADDR_W | Destination pointer |

## Verification
The bench covers every combination of bus width, the two sizes, pointer parity and increment enables. For each one it checks the address, size, direction and data of every cycle, along with the final pointers.

The main failure modes it targets are these:
- A split odd-address access that uses a step of 2 would land its second byte on the wrong address.
- Swapped byte lanes during packing would reverse the data.
- A wrong entry in the step table, such as +2 in place of +4 on the byte side of a packed move, would show up in the final pointers.

Errors on a read and on a write must leave the pointers untouched. A start or load that arrives mid-operand must not disturb the cycles in flight or the final pointers.

// File: rtl/dma_pack_pkg.sv
package dma_pack_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef struct packed {
    logic       capWord;   // capture full read word
    logic       capHi;     // capture read byte into upper half
    logic       capLo;     // capture read byte into lower half
    logic       wrWord;    // current write drives the whole holding word
    logic       wrLo;      // byte write drives the lower half
    logic       commit;    // final write accepted cleanly
    logic [1:0] offset;    // address offset from the active pointer
    logic [2:0] srcStep;
    logic [2:0] dstStep;
  } seqStrobes_t;

  function automatic logic [2:0] stepFor(input logic wide, input logic thisWord,
                                         input logic otherWord);
    if (!wide)          return 3'd1;
    else if (thisWord)  return 3'd2;
    else if (otherWord) return 3'd4;
    else                return 3'd1;
  endfunction
endpackage

// File: rtl/dma_pack_ctrl.sv
module dma_pack_ctrl
  import dma_pack_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        busWide,
  input  logic        srcWord,
  input  logic        dstWord,
  input  logic        srcOdd,
  input  logic        dstOdd,
  input  logic        cycAck,
  input  logic        cycErr,
  output logic        cycReq,
  output logic        cycWrite,
  output logic        cycWord,
  output logic        busy,
  output logic        opDone,
  output logic        opErr,
  output seqStrobes_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} seqState_t;

  seqState_t state;
  logic      idx;
  logic      rdTwo, rdWord, rdStep2;
  logic      wrTwo, wrWord, wrStep2;
  logic [2:0] srcStepQ, dstStepQ;
  logic      accept, good, lastRd, lastWr;

  assign cycReq   = (state != ST_IDLE);
  assign cycWrite = (state == ST_WRITE);
  assign cycWord  = cycWrite ? wrWord : rdWord;
  assign busy     = cycReq;
  assign accept   = cycReq & cycAck;
  assign good     = accept & ~cycErr;
  assign lastRd   = ~rdTwo | idx;
  assign lastWr   = ~wrTwo | idx;

  always_comb begin
    strb         = '0;
    strb.srcStep = srcStepQ;
    strb.dstStep = dstStepQ;
    strb.wrWord  = wrWord;
    strb.wrLo    = idx;
    if (state == ST_READ) begin
      strb.capWord = good & rdWord;
      strb.capHi   = good & ~rdWord & ~idx;
      strb.capLo   = good & ~rdWord & idx;
      strb.offset  = idx ? (rdStep2 ? 2'd2 : 2'd1) : 2'd0;
    end else if (state == ST_WRITE) begin
      strb.commit  = good & lastWr;
      strb.offset  = idx ? (wrStep2 ? 2'd2 : 2'd1) : 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idx      <= 1'b0;
      rdTwo    <= 1'b0;
      rdWord   <= 1'b0;
      rdStep2  <= 1'b0;
      wrTwo    <= 1'b0;
      wrWord   <= 1'b0;
      wrStep2  <= 1'b0;
      srcStepQ <= 3'd0;
      dstStepQ <= 3'd0;
      opDone   <= 1'b0;
      opErr    <= 1'b0;
    end else begin
      opDone <= 1'b0;
      opErr  <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          rdTwo    <= busWide & (srcWord ? srcOdd : dstWord);
          rdWord   <= busWide & srcWord & ~srcOdd;
          rdStep2  <= ~srcWord;
          wrTwo    <= busWide & (dstWord ? dstOdd : srcWord);
          wrWord   <= busWide & dstWord & ~dstOdd;
          wrStep2  <= ~dstWord;
          srcStepQ <= stepFor(busWide, srcWord, dstWord);
          dstStepQ <= stepFor(busWide, dstWord, srcWord);
          idx      <= 1'b0;
          state    <= ST_READ;
        end
        ST_READ: if (accept) begin
          if (cycErr) begin
            state <= ST_IDLE;
            opErr <= 1'b1;
          end else if (lastRd) begin
            state <= ST_WRITE;
            idx   <= 1'b0;
          end else begin
            idx <= 1'b1;
          end
        end
        ST_WRITE: if (accept) begin
          if (cycErr) begin
            state <= ST_IDLE;
            opErr <= 1'b1;
          end else if (lastWr) begin
            state  <= ST_IDLE;
            opDone <= 1'b1;
          end else begin
            idx <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Cycle counter kept only for the bound check below.
  logic [2:0] cycCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                        cycCnt <= 3'd0;
    else if (state == ST_IDLE)        cycCnt <= 3'd0;
    else if (accept && cycCnt != 3'd7) cycCnt <= cycCnt + 3'd1;
  end

  assert_cycle_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (cycCnt >= 3'd1 && cycCnt <= 3'd3));

  assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cycReq && !cycAck) |=> (cycReq && $stable(cycWrite) && $stable(cycWord)));
endmodule

// File: rtl/dma_pack_dpath.sv
module dma_pack_dpath
  import dma_pack_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ptrLoad,
  input  logic [ADDR_W-1:0] srcLoad,
  input  logic [ADDR_W-1:0] dstLoad,
  input  logic              busy,
  input  logic              srcIncEn,
  input  logic              dstIncEn,
  input  logic              cycWrite,
  input  logic [WORD_W-1:0] cycRdata,
  input  seqStrobes_t       strb,
  output logic [ADDR_W-1:0] srcPtr,
  output logic [ADDR_W-1:0] dstPtr,
  output logic [ADDR_W-1:0] cycAddr,
  output logic [WORD_W-1:0] cycWdata
);
  logic [WORD_W-1:0] holdReg;
  logic              loadOk;

  assign loadOk = ptrLoad & ~busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPtr <= '0;
      dstPtr <= '0;
    end else if (loadOk) begin
      srcPtr <= srcLoad;
      dstPtr <= dstLoad;
    end else if (strb.commit) begin
      if (srcIncEn) srcPtr <= srcPtr + ADDR_W'(strb.srcStep);
      if (dstIncEn) dstPtr <= dstPtr + ADDR_W'(strb.dstStep);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             holdReg <= '0;
    else if (strb.capWord) holdReg <= cycRdata;
    else if (strb.capHi)   holdReg[WORD_W-1:BYTE_W] <= cycRdata[BYTE_W-1:0];
    else if (strb.capLo)   holdReg[BYTE_W-1:0]      <= cycRdata[BYTE_W-1:0];
  end

  assign cycAddr  = (cycWrite ? dstPtr : srcPtr) + ADDR_W'(strb.offset);
  assign cycWdata = strb.wrWord ? holdReg
                  : {{BYTE_W{1'b0}},
                     strb.wrLo ? holdReg[BYTE_W-1:0] : holdReg[WORD_W-1:BYTE_W]};

  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.commit && !loadOk) |=> ($stable(srcPtr) && $stable(dstPtr)));
endmodule

// File: rtl/dma_pack_seq.sv
module dma_pack_seq
  import dma_pack_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ptrLoad,
  input  logic [ADDR_W-1:0] srcLoad,
  input  logic [ADDR_W-1:0] dstLoad,
  input  logic              srcIncEn,
  input  logic              dstIncEn,
  input  logic              busWide,
  input  logic              srcWord,
  input  logic              dstWord,
  input  logic              start,
  output logic              cycReq,
  output logic              cycWrite,
  output logic              cycWord,
  output logic [ADDR_W-1:0] cycAddr,
  output logic [15:0]       cycWdata,
  input  logic [15:0]       cycRdata,
  input  logic              cycAck,
  input  logic              cycErr,
  output logic              busy,
  output logic              opDone,
  output logic              opErr,
  output logic [ADDR_W-1:0] srcPtr,
  output logic [ADDR_W-1:0] dstPtr
);
  seqStrobes_t strb;

  dma_pack_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .busWide(busWide),
    .srcWord(srcWord), .dstWord(dstWord), .srcOdd(srcPtr[0]), .dstOdd(dstPtr[0]),
    .cycAck(cycAck), .cycErr(cycErr), .cycReq(cycReq), .cycWrite(cycWrite),
    .cycWord(cycWord), .busy(busy), .opDone(opDone), .opErr(opErr), .strb(strb)
  );

  dma_pack_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ptrLoad(ptrLoad), .srcLoad(srcLoad), .dstLoad(dstLoad),
    .busy(busy), .srcIncEn(srcIncEn), .dstIncEn(dstIncEn), .cycWrite(cycWrite),
    .cycRdata(cycRdata), .strb(strb), .srcPtr(srcPtr), .dstPtr(dstPtr),
    .cycAddr(cycAddr), .cycWdata(cycWdata)
  );

  assert_word_even_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cycReq && cycWord) |-> !cycAddr[0]);

  assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cycReq && !cycAck) |=> ($stable(cycAddr) && $stable(cycWdata)));
endmodule

// File: tb/dma_pack_seq_tb.sv
`timescale 1ns/1ps
module dma_pack_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ptrLoad = 1'b0;
  logic [15:0] srcLoad = '0, dstLoad = '0;
  logic        srcIncEn = 1'b0, dstIncEn = 1'b0;
  logic        busWide = 1'b0, srcWord = 1'b0, dstWord = 1'b0, start = 1'b0;
  logic        cycReq, cycWrite, cycWord;
  logic [15:0] cycAddr, cycWdata;
  logic [15:0] cycRdata = '0;
  logic        cycAck = 1'b0, cycErr = 1'b0;
  logic        busy, opDone, opErr;
  logic [15:0] srcPtr, dstPtr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dma_pack_seq u_dut (
    .clk(clk), .rstN(rstN), .ptrLoad(ptrLoad), .srcLoad(srcLoad), .dstLoad(dstLoad),
    .srcIncEn(srcIncEn), .dstIncEn(dstIncEn), .busWide(busWide), .srcWord(srcWord),
    .dstWord(dstWord), .start(start), .cycReq(cycReq), .cycWrite(cycWrite),
    .cycWord(cycWord), .cycAddr(cycAddr), .cycWdata(cycWdata), .cycRdata(cycRdata),
    .cycAck(cycAck), .cycErr(cycErr), .busy(busy), .opDone(opDone), .opErr(opErr),
    .srcPtr(srcPtr), .dstPtr(dstPtr)
  );

  // expected cycle list for one operand
  logic        eWr[4];
  logic        eWord[4];
  logic [15:0] eAddr[4];
  logic [15:0] eData[4];
  int          nCyc;

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic addCyc(input logic wr, input logic wd, input logic [15:0] a,
                        input logic [15:0] d);
    eWr[nCyc] = wr; eWord[nCyc] = wd; eAddr[nCyc] = a; eData[nCyc] = d; nCyc++;
  endtask

  task automatic buildPlan(input logic w, input logic sw, input logic dw,
                           input logic [15:0] s, input logic [15:0] d,
                           input logic [7:0] b0, input logic [7:0] b1);
    nCyc = 0;
    if (!w || (!sw && !dw)) begin
      addCyc(0, 0, s, {8'h0, b0});
      addCyc(1, 0, d, {8'h0, b0});
    end else begin
      if (!sw) begin
        addCyc(0, 0, s, {8'h0, b0}); addCyc(0, 0, s + 16'd2, {8'h0, b1});
      end else if (s[0]) begin
        addCyc(0, 0, s, {8'h0, b0}); addCyc(0, 0, s + 16'd1, {8'h0, b1});
      end else begin
        addCyc(0, 1, s, {b0, b1});
      end
      if (!dw) begin
        addCyc(1, 0, d, {8'h0, b0}); addCyc(1, 0, d + 16'd2, {8'h0, b1});
      end else if (d[0]) begin
        addCyc(1, 0, d, {8'h0, b0}); addCyc(1, 0, d + 16'd1, {8'h0, b1});
      end else begin
        addCyc(1, 1, d, {b0, b1});
      end
    end
  endtask

  task automatic waitReq(input string tag);
    int n = 0;
    while (!cycReq && n < 20) begin @(negedge clk); n++; end
    if (!cycReq) check(tag, "request timeout", 0, 1);
  endtask

  task automatic loadPtrs(input logic [15:0] s, input logic [15:0] d);
    srcLoad = s; dstLoad = d; ptrLoad = 1'b1;
    @(negedge clk); ptrLoad = 1'b0;
  endtask

  task automatic runOp(input logic w, input logic sw, input logic dw, input logic so,
                       input logic dOdd, input logic si, input logic di, input int i,
                       input logic disturb);
    logic [15:0] s, d, expS, expD;
    logic [7:0]  b0, b1;
    string tag;
    logic [2:0]  stS, stD;
    s = 16'h1000 + 16'(i * 8) + {15'd0, so};
    d = 16'h8000 + 16'(i * 8) + {15'd0, dOdd};
    b0 = 8'h11 + 8'(i); b1 = 8'hC0 ^ 8'(i * 3);
    if (!w) tag = "R1";
    else if ((sw && so) || (dw && dOdd)) tag = "R6";
    else if (!sw && !dw) tag = "R2";
    else if (!sw) tag = "R3";
    else if (!dw) tag = "R4";
    else tag = "R5";
    stS = !w ? 3'd1 : sw ? 3'd2 : dw ? 3'd4 : 3'd1;
    stD = !w ? 3'd1 : dw ? 3'd2 : sw ? 3'd4 : 3'd1;
    expS = s + (si ? 16'(stS) : 16'd0);
    expD = d + (di ? 16'(stD) : 16'd0);
    buildPlan(w, sw, dw, s, d, b0, b1);
    loadPtrs(s, d);
    busWide = w; srcWord = sw; dstWord = dw; srcIncEn = si; dstIncEn = di;
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int k = 0; k < nCyc; k++) begin
      waitReq(tag);
      if (disturb && k == 0) begin  // R10: start and load mid-operand
        start = 1'b1; ptrLoad = 1'b1; srcLoad = 16'hDEAD; dstLoad = 16'hBEEF;
        @(negedge clk); start = 1'b0; ptrLoad = 1'b0;
      end
      if ((i + k) % 3 == 0) @(negedge clk);  // stall: request must hold (R9)
      check(tag, "cycReq", cycReq, 1);
      check(tag, "cycWrite", cycWrite, eWr[k]);
      check(tag, "cycWord", cycWord, eWord[k]);
      check(tag, "cycAddr", cycAddr, eAddr[k]);
      if (eWr[k]) check(tag, "cycWdata R9", cycWdata, eData[k]);
      else cycRdata = eWord[k] ? eData[k] : {8'hEE, eData[k][7:0]};
      cycAck = 1'b1; @(negedge clk); cycAck = 1'b0; cycRdata = '0;
    end
    // R11: no fifth cycle, done pulse after the last acknowledged cycle
    check("R11", "extra request", cycReq, 0);
    check("R8", "opDone", opDone, 1);
    check("R8", "busy", busy, 0);
    check((si && di) ? tag : "R7", "srcPtr", srcPtr, expS);
    check((si && di) ? tag : "R7", "dstPtr", dstPtr, expD);
    @(negedge clk);
    check("R8", "opDone single pulse", opDone, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8", "reset busy", busy, 0);
    check("R8", "reset cycReq", cycReq, 0);
    check("R8", "reset opDone", opDone, 0);
    check("R8", "reset srcPtr", srcPtr, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int c = 0; c < 128; c++)
      runOp(c[6], c[5], c[4], c[3], c[2], c[1], c[0], c, 1'b0);

    // R10: start and load during an operand are ignored
    runOp(1, 0, 1, 0, 1, 1, 1, 7, 1'b1);
    runOp(1, 1, 0, 1, 0, 1, 1, 9, 1'b1);

    // R8: error on the read phase
    loadPtrs(16'h3000, 16'h4000);
    busWide = 1; srcWord = 1; dstWord = 1; srcIncEn = 1; dstIncEn = 1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    waitReq("R8");
    cycAck = 1'b1; cycErr = 1'b1; @(negedge clk); cycAck = 1'b0; cycErr = 1'b0;
    check("R8", "opErr read", opErr, 1);
    check("R8", "opDone read err", opDone, 0);
    check("R8", "busy after err", busy, 0);
    check("R8", "srcPtr after err", srcPtr, 16'h3000);
    check("R8", "dstPtr after err", dstPtr, 16'h4000);

    // R8: error on the write phase
    start = 1'b1; @(negedge clk); start = 1'b0;
    waitReq("R8");
    cycRdata = 16'h1234; cycAck = 1'b1; @(negedge clk); cycAck = 1'b0;
    waitReq("R8");
    check("R8", "write phase", cycWrite, 1);
    check("R8", "write data", cycWdata, 16'h1234);
    cycAck = 1'b1; cycErr = 1'b1; @(negedge clk); cycAck = 1'b0; cycErr = 1'b0;
    check("R8", "opErr write", opErr, 1);
    check("R8", "srcPtr after write err", srcPtr, 16'h3000);
    check("R8", "dstPtr after write err", dstPtr, 16'h4000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule